// File: doc/BRIEF.md
# Conditional Flow Control Sequencer

This block carries out the conditional branch group of an 8-bit processor with a 16-bit program counter and stack pointer: conditional absolute jumps, conditional calls and conditional returns. The surrounding core hands it the opcode, the flag byte, the current program counter (the address of the opcode byte) and the stack pointer, all sampled with a one-cycle `start` strobe. The block then runs the needed memory sequence over one byte-wide synchronous port, and reports the next program counter, the next stack pointer and the number of processor cycles the instruction costs, together with a one-cycle `done` pulse.

The condition is chosen by opcode bits 5:3 and tests one flag bit for clear or set. The class is chosen by opcode bits 2:0. Jumps and calls always fetch their two-byte little-endian target. A taken call pushes the return address, high byte first. A taken return pops a new program counter, low byte first. The memory port is synchronous: an address presented with `mem_rd` in one cycle returns its byte on `mem_rdata` in the next cycle.

Top module: `cond_branch_seq`

## Requirements
- R1: After reset `busy`, `done`, `mem_rd` and `mem_wr` are 0, and `pc_out`, `sp_out` and `cycles` are 0.
- R2: The condition index is opcode bits 5:3. Indices 0/1 test Z (flag bit 6), indices 2/3 test C (bit 0), indices 4/5 test P/V (bit 2) and indices 6/7 test S (bit 7). An even index holds when the flag is 0. An odd index holds when the flag is 1.
- R3: Only opcodes with bits 7:6 = 11 and bits 2:0 of 000 (return), 010 (jump) or 100 (call) are handled. Any other opcode gives `done` right after the edge that samples `start`, with `pc_out`=pc, `sp_out`=sp, `cycles`=0 and no memory access.
- R4: A jump reads the low target byte at pc+1 and then the high byte at pc+2. It sets `pc_out` to the target if the condition holds and to pc+3 if it does not. It leaves sp unchanged, reports 10 cycles, and raises `done` 3 edges after the sampling edge.
- R5: A taken call writes the high byte of pc+3 at sp-1 and then the low byte at sp-2. It gives `pc_out`=target, `sp_out`=sp-2 and 17 cycles, with `done` 5 edges after the sampling edge.
- R6: A call whose condition fails makes exactly two reads and no writes. It gives pc+3, the unchanged sp and 10 cycles, with `done` 3 edges after the sampling edge.
- R7: A taken return reads the low byte at sp and then the high byte at sp+1. It gives `pc_out`={high,low}, `sp_out`=sp+2 and 11 cycles, with `done` 3 edges after the sampling edge.
- R8: A return whose condition fails makes no memory access. It gives pc+1, the unchanged sp and 5 cycles, with `done` right after the sampling edge.
- R9: `start` is ignored while `busy` is 1.
- R10: `done` lasts one cycle, and `pc_out`, `sp_out` and `cycles` hold their values until the next `done`.
- R11: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one instruction (sampled when idle) |
| opcode | input | 8 | Instruction opcode |
| flags | input | 8 | Flag byte (S bit 7, Z bit 6, P/V bit 2, C bit 0) |
| pc_in | input | 16 | Address of the opcode byte |
| sp_in | input | 16 | Stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe; data returns the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Next program counter |
| sp_out | output | 16 | Next stack pointer |
| cycles | output | 5 | Processor cycle cost of the instruction |

## Verification
Counted from the clock edge that samples `start`, `done` and the results are due 0 edges later for an unhandled opcode or an untaken return. They are due 3 edges later for a jump, an untaken call or a taken return, and 5 edges later for a taken call. Each scenario task drives `start` on a falling edge. It then counts falling edges until `done`, checks that count against the expected latency, and reads every result on that same falling edge. On the falling edge after that it checks that `done` has dropped and that the results are held. Memory reads and writes are counted by the bench memory model at rising edges, and the pushed bytes are read back from that model.

// File: rtl/cond_branch_seq.sv
module cond_branch_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [7:0]  flags,
  input  logic [15:0] pc_in,
  input  logic [15:0] sp_in,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic [15:0] sp_out,
  output logic [4:0]  cycles
);
  localparam logic [4:0] CYC_JMP = 5'd10, CYC_CALL_T = 5'd17, CYC_CALL_N = 5'd10;
  localparam logic [4:0] CYC_RET_T = 5'd11, CYC_RET_N = 5'd5;

  typedef enum logic [3:0] {S_IDLE, S_TLO, S_THI, S_TCAP, S_PSH_H, S_PSH_L,
                            S_POP_L, S_POP_H, S_PCAP} st_t;
  st_t st;

  logic [7:0]  op_l, lo_l;
  logic [15:0] pc_l, sp_l, tgt_l;
  logic        taken_l;

  logic       flag_bit, cond_ok, is_ret, is_jmp, is_call, valid;
  logic [2:0] cidx;
  assign cidx = opcode[5:3];
  always_comb begin
    case (cidx[2:1])
      2'd0: flag_bit = flags[6];
      2'd1: flag_bit = flags[0];
      2'd2: flag_bit = flags[2];
      default: flag_bit = flags[7];
    endcase
  end
  assign cond_ok = (flag_bit == cidx[0]);
  assign is_ret  = (opcode[2:0] == 3'b000);
  assign is_jmp  = (opcode[2:0] == 3'b010);
  assign is_call = (opcode[2:0] == 3'b100);
  assign valid   = (opcode[7:6] == 2'b11) && (is_ret || is_jmp || is_call);

  logic [15:0] ret_addr;
  assign ret_addr = pc_l + 16'd3;
  assign busy = (st != S_IDLE);

  always_comb begin
    mem_addr  = 16'h0000;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = 8'h00;
    case (st)
      S_TLO:   begin mem_addr = pc_l + 16'd1; mem_rd = 1'b1; end
      S_THI:   begin mem_addr = pc_l + 16'd2; mem_rd = 1'b1; end
      S_PSH_H: begin mem_addr = sp_l - 16'd1; mem_wr = 1'b1; mem_wdata = ret_addr[15:8]; end
      S_PSH_L: begin mem_addr = sp_l - 16'd2; mem_wr = 1'b1; mem_wdata = ret_addr[7:0]; end
      S_POP_L: begin mem_addr = sp_l;         mem_rd = 1'b1; end
      S_POP_H: begin mem_addr = sp_l + 16'd1; mem_rd = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0;
      pc_out <= '0; sp_out <= '0; cycles <= '0;
      op_l <= '0; lo_l <= '0; pc_l <= '0; sp_l <= '0; tgt_l <= '0; taken_l <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_l <= opcode; pc_l <= pc_in; sp_l <= sp_in; taken_l <= cond_ok;
          if (!valid) begin
            done <= 1'b1; pc_out <= pc_in; sp_out <= sp_in; cycles <= 5'd0;
          end else if (is_ret) begin
            if (cond_ok) st <= S_POP_L;
            else begin
              done <= 1'b1; pc_out <= pc_in + 16'd1; sp_out <= sp_in; cycles <= CYC_RET_N;
            end
          end else st <= S_TLO;
        end
        S_TLO: st <= S_THI;
        S_THI: begin lo_l <= mem_rdata; st <= S_TCAP; end
        S_TCAP: begin
          if (op_l[2] && taken_l) begin
            tgt_l <= {mem_rdata, lo_l};
            st <= S_PSH_H;
          end else begin
            done <= 1'b1; st <= S_IDLE; sp_out <= sp_l;
            pc_out <= taken_l ? {mem_rdata, lo_l} : ret_addr;
            cycles <= op_l[2] ? CYC_CALL_N : CYC_JMP;
          end
        end
        S_PSH_H: st <= S_PSH_L;
        S_PSH_L: begin
          done <= 1'b1; st <= S_IDLE;
          pc_out <= tgt_l; sp_out <= sp_l - 16'd2; cycles <= CYC_CALL_T;
        end
        S_POP_L: st <= S_POP_H;
        S_POP_H: begin lo_l <= mem_rdata; st <= S_PCAP; end
        S_PCAP: begin
          done <= 1'b1; st <= S_IDLE;
          pc_out <= {mem_rdata, lo_l}; sp_out <= sp_l + 16'd2; cycles <= CYC_RET_T;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_cost_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles == 5'd0 || cycles == 5'd5 || cycles == 5'd10 ||
              cycles == 5'd11 || cycles == 5'd17));
  assert_pop_stack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cycles == 5'd11) |-> (sp_out == sp_l + 16'd2));
  assert_write_only_taken_call_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (op_l[2:0] == 3'b100 && taken_l));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(pc_l) && $stable(sp_l) && $stable(op_l)));
  assert_untaken_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cycles == 5'd5) |-> (pc_out == pc_l + 16'd1 && sp_out == sp_l));
endmodule

// File: tb/cond_branch_seq_tb.sv
module cond_branch_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = 8'h00, flags = 8'h00;
  logic [15:0] pc_in = 16'h0000, sp_in = 16'h0000;
  logic [15:0] mem_addr, pc_out, sp_out;
  logic mem_rd, mem_wr, busy, done;
  logic [7:0] mem_wdata, mem_rdata;
  logic [4:0] cycles;

  always #2.5 clk = ~clk;

  cond_branch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .flags(flags),
    .pc_in(pc_in), .sp_in(sp_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out), .cycles(cycles));

  logic [7:0] mem [0:1023];
  int rd_cnt = 0, wr_cnt = 0;
  int checks = 0, failures = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (mem_wr) begin mem[mem_addr[9:0]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (mem_rd) rd_cnt <= rd_cnt + 1;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit cond_holds(input logic [7:0] op, input logic [7:0] f);
    logic b;
    case (op[5:4])
      2'd0: b = f[6];
      2'd1: b = f[0];
      2'd2: b = f[2];
      default: b = f[7];
    endcase
    return b == op[3];
  endfunction

  task automatic run(input string tag, input logic [7:0] op, input logic [7:0] f,
                     input logic [15:0] pc, input logic [15:0] sp);
    logic [15:0] tgt, popv, epc, esp, ra, a1, a2, s1;
    int ecyc, elat, erd, ewr, lat;
    bit tk, valid;
    tgt = ~pc ^ 16'h0F0F; popv = sp ^ 16'h1234; ra = pc + 16'd3;
    a1 = pc + 16'd1; a2 = pc + 16'd2; s1 = sp + 16'd1;
    mem[a1[9:0]] = tgt[7:0]; mem[a2[9:0]] = tgt[15:8];
    mem[sp[9:0]] = popv[7:0]; mem[s1[9:0]] = popv[15:8];
    tk = cond_holds(op, f);
    valid = (op[7:6] == 2'b11) && (op[2:0] == 3'b000 || op[2:0] == 3'b010 || op[2:0] == 3'b100);
    epc = pc; esp = sp; ecyc = 0; elat = 0; erd = 0; ewr = 0;
    if (valid && op[2:0] == 3'b000) begin
      if (tk) begin epc = popv; esp = sp + 16'd2; ecyc = 11; elat = 3; erd = 2; end
      else begin epc = pc + 16'd1; ecyc = 5; end
    end else if (valid && op[2:0] == 3'b010) begin
      epc = tk ? tgt : ra; ecyc = 10; elat = 3; erd = 2;
    end else if (valid) begin
      if (tk) begin epc = tgt; esp = sp - 16'd2; ecyc = 17; elat = 5; erd = 2; ewr = 2; end
      else begin epc = ra; ecyc = 10; elat = 3; erd = 2; end
    end
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    opcode = op; flags = f; pc_in = pc; sp_in = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    chk(tag, "latency", lat, elat);
    chk(tag, "pc_out", pc_out, epc);
    chk(tag, "sp_out", sp_out, esp);
    chk(tag, "cycles", cycles, ecyc);
    chk(tag, "reads", rd_cnt, erd);
    chk(tag, "writes", wr_cnt, ewr);
    if (ewr == 2) begin
      chk(tag, "push hi", mem[(sp - 16'd1) & 16'h03FF], ra[15:8]);
      chk(tag, "push lo", mem[(sp - 16'd2) & 16'h03FF], ra[7:0]);
    end
    @(negedge clk);
    chk("R10", "done pulse", done, 0);
    chk("R10", "pc held", pc_out, epc);
    chk("R10", "cycles held", cycles, ecyc);
  endtask

  task automatic reset_check;
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "strobes", {mem_rd, mem_wr}, 0);
    chk("R1", "pc_out", pc_out, 0);
    chk("R1", "sp_out", sp_out, 0);
    chk("R1", "cycles", cycles, 0);
  endtask

  task automatic busy_start_check;
    int lat;
    mem[10'h101] = 8'h34; mem[10'h102] = 8'h12;
    @(negedge clk);
    opcode = 8'hC2; flags = 8'h00; pc_in = 16'h0100; sp_in = 16'h0300; start = 1'b1;
    @(negedge clk);
    opcode = 8'hC8; flags = 8'h00; pc_in = 16'h0200; sp_in = 16'h0050;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    chk("R9", "latency", lat, 3);
    chk("R9", "pc_out", pc_out, 16'h1234);
    chk("R9", "sp_out", sp_out, 16'h0300);
    @(negedge clk);
    chk("R9", "no second done", done, 0);
    @(negedge clk);
    chk("R9", "still idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();
    // R2 with R4: each condition index against single-flag patterns
    for (int i = 0; i < 8; i++) begin
      logic [7:0] fl [6];
      fl = '{8'h00, 8'hFF, 8'h40, 8'h01, 8'h04, 8'h80};
      for (int j = 0; j < 6; j++)
        run("R4", 8'hC2 | 8'(i << 3), fl[j], 16'h0120 + 16'(i * 8), 16'h0380);
    end
    for (int i = 0; i < 8; i++) begin
      run("R5", 8'hC4 | 8'(i << 3), (i[0] ? 8'hFF : 8'h00), 16'h0040, 16'h0300);
      run("R6", 8'hC4 | 8'(i << 3), (i[0] ? 8'h00 : 8'hFF), 16'h0044, 16'h0300);
      run("R7", 8'hC0 | 8'(i << 3), (i[0] ? 8'hFF : 8'h00), 16'h0060, 16'h0310);
      run("R8", 8'hC0 | 8'(i << 3), (i[0] ? 8'h00 : 8'hFF), 16'h0064, 16'h0310);
    end
    run("R2", 8'hCA, 8'hBF, 16'h0080, 16'h0300);
    run("R2", 8'hF2, 8'h7F, 16'h0084, 16'h0300);
    run("R3", 8'hC3, 8'h00, 16'h0088, 16'h0300);
    run("R3", 8'h02, 8'h00, 16'h008C, 16'h0300);
    run("R3", 8'hC6, 8'hFF, 16'h0090, 16'h0300);
    run("R11", 8'hC2, 8'h00, 16'hFFFE, 16'h0300);
    run("R11", 8'hC4, 8'h00, 16'h00A0, 16'h0001);
    run("R11", 8'hC0, 8'h00, 16'h00B0, 16'hFFFF);
    busy_start_check();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule